// File: doc/BRIEF.md
# Flash Program/Erase Status Engine

This block is a synthesizable behavioural model of the controller that sits behind the command decoder of a byte-wide NOR flash. It accepts a start pulse for a single-byte program or for a whole-array erase. It then keeps the device busy for a fixed number of clocks, set by a parameter, and commits the result to a small parameterized array. The analog program and erase pulses are modelled only as this cycle delay.

In array-read mode a read strobe returns the stored byte. While an operation runs, and after a failed program, every read returns a status byte instead, whatever the address. In that byte, bit 7 is a polling bit, bit 6 is a toggle bit and bit 5 is a failure bit. Programming can only clear bits; an attempt to raise a 0 to 1 leaves a sticky error. An abort request clears that error. An abort request also cuts an erase short, after an abort interval of its own.

Top module: `flash_pe_engine`

## Requirements
- R1: After reset `busy` and `error` are 0 and every array byte reads FFh.
- R2: In array-read mode a read strobed in one cycle shows `array[rd_addr]` on `rd_data` after the next clock edge. `rd_data` holds its value while no read is strobed.
- R3: A program start accepted in array-read mode holds `busy` high for exactly PROG_CYC cycles. The array byte then becomes stored AND written data, and if that equals the written data the block returns to array-read mode with `error` 0.
- R4: While a program runs, a read at any address returns the status byte. Its bit 7 is the complement of bit 7 of the data being written, bit 5 is 0 and bits 4..0 are 0.
- R5: Status bit 6 reads 0 on the first status read after an operation starts and inverts on each later status read.
- R6: If stored AND written data differs from the written data, then at the end of the program the array holds the AND result, `busy` falls and `error` rises. Reads then return status with bit 5 = 1, bit 7 still the complement of written bit 7, and bit 6 still toggling.
- R7: In the error state every start is ignored. An abort request returns the block to array-read mode with `error` 0.
- R8: While a program runs, abort requests and new program or erase starts have no effect on its length or its result.
- R9: An erase start holds `busy` for exactly ERASE_CYC cycles, with status bit 7 = 0 meanwhile, and then leaves every byte at FFh.
- R10: An abort request during an erase ends it. `busy` then stays high for ABORT_CYC cycles after the abort edge, reads return 00h during that time, and the block then returns to array-read mode with `error` 0.
- R11: In array-read mode, simultaneous program and erase starts run the program. An abort request in array-read mode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_start | input | 1 | Single-cycle request to program one byte |
| erase_start | input | 1 | Single-cycle request to erase the whole array |
| op_addr | input | ADDR_W | Byte address for a program |
| op_data | input | 8 | Data for a program |
| abort_req | input | 1 | Reset request: clears an error or aborts an erase |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Array byte or status byte, registered |
| busy | output | 1 | Program, erase or abort in progress |
| error | output | 1 | Sticky program failure |

## Verification
A read can land in the last busy cycle, on the very edge at which the program commits and the engine leaves the busy state. The bench strobes a read in that cycle and expects a status byte whose toggle bit continues the sequence. It then strobes a read one cycle later and expects the committed array byte. A second clash is an abort request arriving together with fresh starts in the middle of a program. The bench judges that case by the unchanged busy length and by the stored byte at both addresses involved.

// File: rtl/flash_pe_pkg.sv
`timescale 1ns/1ps
// Shared types for the program/erase status engine.
// Assumes a byte-wide array; the status byte layout depends on that.
package flash_pe_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_READ,
        ST_PROG,
        ST_ERASE,
        ST_ABORT,
        ST_FAIL
    } eng_state_t;

    typedef enum logic [1:0] {
        SRC_ARRAY,
        SRC_STATUS,
        SRC_BLANK
    } rd_src_t;

    // Builds the status byte: poll in bit 7, toggle in bit 6, failure in bit 5.
    function automatic logic [BYTE_W-1:0] status_byte(input logic poll,
                                                      input logic tog,
                                                      input logic fail);
        return {poll, tog, fail, 5'b0_0000};
    endfunction
endpackage

// File: rtl/flash_pe_array.sv
`timescale 1ns/1ps
// Byte storage for the engine: one write port, one bulk erase, and two
// combinational read ports (host read and read-before-write for the sequencer).
// Assumes the write and the erase are never requested in the same cycle.
module flash_pe_array #(
    parameter int ADDR_W = 6,
    parameter int DEPTH  = 1 << ADDR_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [flash_pe_pkg::BYTE_W-1:0]  wr_data,
    input  logic                             erase_all,
    input  logic [ADDR_W-1:0]                host_addr,
    output logic [flash_pe_pkg::BYTE_W-1:0]  host_data,
    input  logic [ADDR_W-1:0]                cell_addr,
    output logic [flash_pe_pkg::BYTE_W-1:0]  cell_data
);
    import flash_pe_pkg::*;

    logic [BYTE_W-1:0] mem [DEPTH];

    // Storage update: all ones at reset or erase, single byte on write.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_all) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Read ports.
    always_comb begin
        host_data = mem[host_addr];
        cell_data = mem[cell_addr];
    end

    a_r9_erase_fills: assert property (@(posedge clk) disable iff (!rst_n)
        erase_all |=> (mem[0] == '1 && mem[DEPTH-1] == '1));
endmodule

// File: rtl/flash_pe_seq.sv
`timescale 1ns/1ps
// Operation sequencer: accepts program/erase starts, counts the operation
// length, commits the result, enters the sticky failure state, and handles
// the abort of an erase. Assumes the start pulses last one cycle.
module flash_pe_seq #(
    parameter int ADDR_W    = 6,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 12,
    parameter int ABORT_CYC = 5
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               prog_start,
    input  logic                               erase_start,
    input  logic [ADDR_W-1:0]                  op_addr,
    input  logic [flash_pe_pkg::BYTE_W-1:0]    op_data,
    input  logic                               abort_req,
    input  logic [flash_pe_pkg::BYTE_W-1:0]    cell_data,
    output flash_pe_pkg::eng_state_t           st,
    output logic [ADDR_W-1:0]                  tgt_addr,
    output logic                               poll_bit,
    output logic                               op_launch,
    output logic                               wr_en,
    output logic [flash_pe_pkg::BYTE_W-1:0]    wr_data,
    output logic                               erase_all
);
    import flash_pe_pkg::*;

    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC)
                           ? ((PROG_CYC > ABORT_CYC) ? PROG_CYC : ABORT_CYC)
                           : ((ERASE_CYC > ABORT_CYC) ? ERASE_CYC : ABORT_CYC);
    localparam int CNT_W = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] tgt_data;
    logic [BYTE_W-1:0] merged;
    logic              fail_now;
    logic              cnt_done;

    // Result of the program and its pass/fail verdict.
    always_comb begin
        merged   = cell_data & tgt_data;
        fail_now = (merged != tgt_data);
        cnt_done = (cnt == '0);
    end

    // State, counter and operand latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_READ;
            cnt      <= '0;
            tgt_addr <= '0;
            tgt_data <= '0;
            poll_bit <= 1'b0;
        end else begin
            unique case (st)
                ST_READ: begin
                    if (prog_start) begin
                        st       <= ST_PROG;
                        cnt      <= CNT_W'(PROG_CYC - 1);
                        tgt_addr <= op_addr;
                        tgt_data <= op_data;
                        poll_bit <= ~op_data[BYTE_W-1];
                    end else if (erase_start) begin
                        st       <= ST_ERASE;
                        cnt      <= CNT_W'(ERASE_CYC - 1);
                        poll_bit <= 1'b0;
                    end
                end
                ST_PROG: begin
                    if (cnt_done) st <= fail_now ? ST_FAIL : ST_READ;
                    else          cnt <= cnt - 1'b1;
                end
                ST_ERASE: begin
                    if (abort_req) begin
                        st  <= ST_ABORT;
                        cnt <= CNT_W'(ABORT_CYC - 1);
                    end else if (cnt_done) begin
                        st <= ST_READ;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_ABORT: begin
                    if (cnt_done) st <= ST_READ;
                    else          cnt <= cnt - 1'b1;
                end
                ST_FAIL: begin
                    if (abort_req) st <= ST_READ;
                end
                default: st <= ST_READ;
            endcase
        end
    end

    // Array write controls and launch pulse for the status port.
    always_comb begin
        wr_en     = (st == ST_PROG) && cnt_done;
        wr_data   = merged;
        erase_all = (st == ST_ERASE) && cnt_done && !abort_req;
        op_launch = (st == ST_READ) && (prog_start || erase_start);
    end

    a_r8_prog_runs_on: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG && !cnt_done) |=> (st == ST_PROG));

    a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FAIL && !abort_req) |=> (st == ST_FAIL));

    a_r6_fail_from_prog: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FAIL && $past(st) != ST_FAIL) |-> ($past(st) == ST_PROG));

    a_r10_abort_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ABORT) |-> (cnt < CNT_W'(ABORT_CYC)));
endmodule

// File: rtl/flash_pe_rdport.sv
`timescale 1ns/1ps
// Read port: picks array data, the status byte or a blank byte by engine
// state, registers the result, and keeps the toggle bit. Assumes a status
// read is any strobed read outside array-read and abort states.
module flash_pe_rdport (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             rd_en,
    input  flash_pe_pkg::eng_state_t         st,
    input  logic                             poll_bit,
    input  logic                             op_launch,
    input  logic [flash_pe_pkg::BYTE_W-1:0]  arr_data,
    output logic [flash_pe_pkg::BYTE_W-1:0]  rd_data
);
    import flash_pe_pkg::*;

    rd_src_t src;
    logic    tog;

    // Source selection by engine state.
    always_comb begin
        unique case (st)
            ST_READ:  src = SRC_ARRAY;
            ST_ABORT: src = SRC_BLANK;
            default:  src = SRC_STATUS;
        endcase
    end

    // Toggle bit: cleared on launch, inverted by each status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                           tog <= 1'b0;
        else if (op_launch)                   tog <= 1'b0;
        else if (rd_en && src == SRC_STATUS)  tog <= ~tog;
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            unique case (src)
                SRC_ARRAY:  rd_data <= arr_data;
                SRC_STATUS: rd_data <= status_byte(poll_bit, tog, st == ST_FAIL);
                default:    rd_data <= '0;
            endcase
        end
    end

    a_r10_blank_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && st == ST_ABORT) |=> (rd_data == '0));

    a_r4_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && st != ST_READ) |=> (rd_data[4:0] == 5'd0));
endmodule

// File: rtl/flash_pe_engine.sv
`timescale 1ns/1ps
// Top of the program/erase status engine: sequencer, storage and read port.
// Assumes command decoding and bus timing happen upstream.
module flash_pe_engine #(
    parameter int ADDR_W    = 6,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 12,
    parameter int ABORT_CYC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_start,
    input  logic              erase_start,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        op_data,
    input  logic              abort_req,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              error
);
    import flash_pe_pkg::*;

    eng_state_t        st;
    logic [ADDR_W-1:0] tgt_addr;
    logic              poll_bit;
    logic              op_launch;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data;
    logic              erase_all;
    logic [BYTE_W-1:0] host_data;
    logic [BYTE_W-1:0] cell_data;

    flash_pe_seq #(
        .ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC),
        .ERASE_CYC(ERASE_CYC), .ABORT_CYC(ABORT_CYC)
    ) seq_i (
        .clk(clk), .rst_n(rst_n),
        .prog_start(prog_start), .erase_start(erase_start),
        .op_addr(op_addr), .op_data(op_data), .abort_req(abort_req),
        .cell_data(cell_data), .st(st), .tgt_addr(tgt_addr),
        .poll_bit(poll_bit), .op_launch(op_launch),
        .wr_en(wr_en), .wr_data(wr_data), .erase_all(erase_all)
    );

    flash_pe_array #(.ADDR_W(ADDR_W)) array_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(tgt_addr), .wr_data(wr_data),
        .erase_all(erase_all),
        .host_addr(rd_addr), .host_data(host_data),
        .cell_addr(tgt_addr), .cell_data(cell_data)
    );

    flash_pe_rdport rdport_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .st(st),
        .poll_bit(poll_bit), .op_launch(op_launch),
        .arr_data(host_data), .rd_data(rd_data)
    );

    // Flags seen by the host.
    always_comb begin
        busy  = (st == ST_PROG) || (st == ST_ERASE) || (st == ST_ABORT);
        error = (st == ST_FAIL);
    end

    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && error));
endmodule

// File: tb/flash_pe_engine_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the read task queues the expected byte, the monitor
// pops it one edge later and compares it with rd_data.
module flash_pe_engine_tb_top;
    localparam int AW = 6;
    localparam int PC = 8;
    localparam int EC = 12;
    localparam int AC = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_start = 1'b0, erase_start = 1'b0, abort_req = 1'b0;
    logic [AW-1:0] op_addr = '0, rd_addr = '0;
    logic [7:0]    op_data = '0;
    logic          rd_en = 1'b0;
    logic [7:0]    rd_data;
    logic          busy, error;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    flash_pe_engine #(.ADDR_W(AW), .PROG_CYC(PC), .ERASE_CYC(EC), .ABORT_CYC(AC)) dut_i (
        .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .erase_start(erase_start),
        .op_addr(op_addr), .op_data(op_data), .abort_req(abort_req),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .error(error)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_addr = a;
        rd_en   = 1'b1;
        @(negedge clk);
        rd_en   = 1'b0;
    endtask

    task automatic start_prog(input logic [AW-1:0] a, input logic [7:0] d);
        op_addr = a; op_data = d; prog_start = 1'b1;
        @(negedge clk);
        prog_start = 1'b0;
    endtask

    task automatic start_erase();
        erase_start = 1'b1;
        @(negedge clk);
        erase_start = 1'b0;
    endtask

    task automatic flags(input string t, input logic b, input logic e);
        chk({t, " busy"}, {7'd0, busy}, {7'd0, b});
        chk({t, " error"}, {7'd0, error}, {7'd0, e});
    endtask

    // Monitor: compares each read result one edge after its strobe.
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                @(negedge clk);
                if (exp_q.size() == 0) chk("monitor underflow", 8'h00, 8'h01);
                else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        flags("R1 reset", 1'b0, 1'b0);
        rd(0, 8'hFF, "R1 addr0");
        rd(63, 8'hFF, "R1 addr63");

        // R3/R4/R5 program ok, read on the commit edge
        start_prog(5, 8'h3C);                      // now 1st busy cycle
        flags("R3 prog start", 1'b1, 1'b0);
        rd(7, 8'h80, "R4 status first");          // poll=~0, tog=0
        rd(5, 8'hC0, "R5 toggle second");
        tick(5);                                   // last busy cycle
        flags("R3 last busy cycle", 1'b1, 1'b0);
        rd(0, 8'h80, "R5 read on commit edge");
        flags("R3 after prog", 1'b0, 1'b0);
        rd(5, 8'h3C, "R2 array after prog");
        tick(1);
        chk("R2 hold", rd_data, 8'h3C);
        rd(6, 8'hFF, "R2 untouched byte");

        // R8 program ignores abort and new starts
        start_prog(9, 8'hA5);
        op_addr = 10; op_data = 8'h00;
        prog_start = 1'b1; erase_start = 1'b1; abort_req = 1'b1;
        tick(1);
        prog_start = 1'b0; erase_start = 1'b0; abort_req = 1'b0;
        tick(6);
        flags("R8 still busy", 1'b1, 1'b0);
        tick(1);
        flags("R8 done", 1'b0, 1'b0);
        rd(9, 8'hA5, "R8 programmed byte");
        rd(10, 8'hFF, "R8 ignored program");

        // R6/R7 failing program (3C & 43 = 00)
        start_prog(5, 8'h43);
        rd(5, 8'h80, "R4 status no fail yet");
        tick(7);
        flags("R6 fail flags", 1'b0, 1'b1);
        rd(5, 8'hE0, "R6 fail status");
        rd(2, 8'hA0, "R6 fail toggle");
        start_erase();
        flags("R7 erase ignored in fail", 1'b0, 1'b1);
        abort_req = 1'b1; tick(1); abort_req = 1'b0;
        flags("R7 cleared", 1'b0, 1'b0);
        rd(5, 8'h00, "R6 stored AND");

        // R9 erase
        start_erase();
        rd(0, 8'h00, "R9 status first");
        rd(1, 8'h40, "R9 status toggle");
        tick(9);
        flags("R9 last busy", 1'b1, 1'b0);
        tick(1);
        flags("R9 done", 1'b0, 1'b0);
        rd(5, 8'hFF, "R9 erased 5");
        rd(9, 8'hFF, "R9 erased 9");

        // R10 abort of an erase
        start_prog(9, 8'h12);
        tick(8);
        start_erase();
        tick(2);
        abort_req = 1'b1; tick(1); abort_req = 1'b0;
        flags("R10 abort busy", 1'b1, 1'b0);
        rd(3, 8'h00, "R10 blank read");
        tick(3);
        flags("R10 abort last", 1'b1, 1'b0);
        tick(1);
        flags("R10 abort done", 1'b0, 1'b0);

        // R11 priority and idle abort
        start_erase();
        tick(12);
        abort_req = 1'b1; tick(1); abort_req = 1'b0;
        flags("R11 idle abort", 1'b0, 1'b0);
        op_addr = 20; op_data = 8'h7E; prog_start = 1'b1; erase_start = 1'b1;
        tick(1);
        prog_start = 1'b0; erase_start = 1'b0;
        tick(7);
        flags("R11 busy", 1'b1, 1'b0);
        tick(1);
        flags("R11 program length", 1'b0, 1'b0);
        rd(20, 8'h7E, "R11 program won");
        rd(21, 8'hFF, "R11 no erase side effect");

        tick(3);
        if (exp_q.size() != 0) chk("scoreboard drained", 8'(exp_q.size()), 8'h00);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule